// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block sequences the operating modes of a small processor core and produces its system clock enable. Two run modes exist. In NORMAL the core is clocked from the high-speed oscillator through a power-of-two divider. In SLOW it is clocked from the low-speed sub-oscillator. A halt request moves the core into one of four low-power modes. Two idle-enable bits choose the mode by saying which oscillators stay running.

A one-cycle wake event returns the core to the run mode it left. Leaving SLOW for NORMAL while the high-speed oscillator is not yet stable keeps the core on the slow clock until the stable flag arrives. Entering any low-power mode raises the power-down flag, clears the timeout flag and pulses a watchdog clear. The watchdog itself runs on and lies outside this block. The oscillators are modelled only by their enables, a stable flag and a slow-tick input.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: A halt request accepted in a run mode selects the low-power mode from the bits {hs_idle_en, ls_idle_en}: 00 gives SLEEP (mode 2), 01 gives IDLE0 (mode 3), 11 gives IDLE1 (mode 4) and 10 gives IDLE2 (mode 5). The new mode shows on `mode` one cycle after the request.
- R2: In NORMAL (mode 0), clk_sel values n = 0..6 divide by 2^n. While hs_stable is 1, sys_clk_en pulses for one cycle in every 2^n cycles, and div_sel shows the applied n.
- R3: A new clk_sel value takes effect only on a cycle in which sys_clk_en pulses, so every interval between pulses equals the old or the new period.
- R4: clk_sel = 7 moves NORMAL to SLOW (mode 1) at the next sys_clk_en pulse. In SLOW, sys_clk_en equals ls_tick.
- R5: In SLOW, a clk_sel value other than 7 while hs_stable is 0 keeps mode 1, sys_clk_en following ls_tick, and hs_osc_en at 1. The move to NORMAL happens one cycle after hs_stable rises.
- R6: In modes 2 to 5, sys_clk_en is 0.
- R7: hs_osc_en is 1 in NORMAL, IDLE1 and IDLE2, equals hs_idle_en in SLOW, and is 0 in SLEEP and IDLE0. ls_osc_en is 1 in SLOW, IDLE0 and IDLE1, equals ls_idle_en in NORMAL, and is 0 in SLEEP and IDLE2.
- R8: On entry to a low-power mode, pd_flag becomes 1, to_flag becomes 0, and wdt_clr is 1 for exactly one cycle.
- R9: A wake pulse in a low-power mode returns the block to the run mode that was active at the halt. A wake pulse in a run mode is ignored.
- R10: After reset the block is in NORMAL with divide-by-1 (div_sel 0), and pd_flag and to_flag are 0.
- R11: A wdt_tmo pulse sets to_flag one cycle later. The flag stays set until the next halt entry or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request, one cycle |
| hs_idle_en | input | 1 | Keep high-speed oscillator on when halted |
| ls_idle_en | input | 1 | Keep low-speed oscillator on when halted |
| clk_sel | input | 3 | 0..6 divide by 2^n, 7 selects SLOW |
| hs_stable | input | 1 | High-speed oscillator is stable |
| ls_tick | input | 1 | One pulse per low-speed clock period |
| wake | input | 1 | Wake event, one cycle |
| wdt_tmo | input | 1 | Watchdog time-out event |
| mode | output | 3 | 0 NORMAL, 1 SLOW, 2 SLEEP, 3 IDLE0, 4 IDLE1, 5 IDLE2 |
| sys_clk_en | output | 1 | System clock enable |
| div_sel | output | 3 | Applied divider exponent |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Watchdog time-out status flag |
| wdt_clr | output | 1 | Watchdog clear pulse |

## Verification
The assertions check several rules on every cycle: the clock enable stays off in low-power modes, SLEEP has both oscillators off, and SLOW passes the slow tick through. They also check the stall while SLOW waits on the stable flag, the flag updates and single-cycle watchdog clear at halt entry, and that the divider changes only after a clock-enable pulse. The bench scenarios show what needs history or counting. These are the pulse spacing for a given divider, the interval pattern across a divider change, and the mode chosen for each pair of enable bits. They also cover the return to the exact run mode held before the halt and wake events being ignored in run modes.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode and clock controller.
// Assumes a 3-bit mode code; the run/low-power split is encoded by value.
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_SLOW   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_IDLE0  = 3'd3,
        ST_IDLE1  = 3'd4,
        ST_IDLE2  = 3'd5,
        ST_HSWAIT = 3'd6
    } pmc_state_e;

    // True for the states in which the core executes and may halt.
    function automatic logic is_run(input pmc_state_e s);
        return (s == ST_NORMAL) || (s == ST_SLOW) || (s == ST_HSWAIT);
    endfunction
endpackage

// File: rtl/pmc_mode_fsm.sv
// Mode sequencer: run-mode switching, halt decode, wake return and status flags.
// Assumes halt_req and wake are single-cycle events; bnd marks a divided-clock edge.
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             hs_idle_en,
    input  logic             ls_idle_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             hs_stable,
    input  logic             bnd,
    input  logic             wake,
    input  logic             wdt_tmo,
    output pmc_state_e       state_q,
    output logic             pd_flag,
    output logic             to_flag,
    output logic             wdt_clr
);
    localparam logic [SEL_W-1:0] SEL_SLOW = '1;

    pmc_state_e state_d;
    pmc_state_e lp_sel;
    pmc_state_e ret_q;
    logic       halt_go;
    logic       want_slow;

    // Decode the low-power target from the two idle-enable bits.
    always_comb begin
        unique case ({hs_idle_en, ls_idle_en})
            2'b00:   lp_sel = ST_SLEEP;
            2'b01:   lp_sel = ST_IDLE0;
            2'b11:   lp_sel = ST_IDLE1;
            default: lp_sel = ST_IDLE2;
        endcase
    end

    assign want_slow = (clk_sel == SEL_SLOW);
    assign halt_go   = halt_req && is_run(state_q);

    // Next-state selection for every mode.
    always_comb begin
        state_d = state_q;
        if (halt_go) begin
            state_d = lp_sel;
        end else begin
            unique case (state_q)
                ST_NORMAL: if (want_slow && bnd) state_d = ST_SLOW;
                ST_SLOW:   if (!want_slow) state_d = hs_stable ? ST_NORMAL : ST_HSWAIT;
                ST_HSWAIT: begin
                    if (want_slow)      state_d = ST_SLOW;
                    else if (hs_stable) state_d = ST_NORMAL;
                end
                default:   if (wake) state_d = ret_q;
            endcase
        end
    end

    // State, return-mode and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            ret_q   <= ST_NORMAL;
            pd_flag <= 1'b0;
            to_flag <= 1'b0;
            wdt_clr <= 1'b0;
        end else begin
            state_q <= state_d;
            wdt_clr <= halt_go;
            if (halt_go) begin
                ret_q   <= (state_q == ST_NORMAL) ? ST_NORMAL : ST_SLOW;
                pd_flag <= 1'b1;
                to_flag <= 1'b0;
            end else if (wdt_tmo) begin
                to_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmc_clk_div.sv
// Divider and clock-enable generator; reloads the divider only on a divided edge.
// Assumes the count stalls in NORMAL while the high-speed oscillator is unstable.
module pmc_clk_div
    import pmc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmc_state_e       state_q,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             hs_stable,
    input  logic             ls_tick,
    output logic             bnd,
    output logic             sys_clk_en,
    output logic [SEL_W-1:0] div_q
);
    localparam int CNT_W = (1 << SEL_W) - 2;
    localparam logic [SEL_W-1:0] SEL_SLOW = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   pow;
    logic             in_norm;

    assign in_norm = (state_q == ST_NORMAL);

    // Terminal count for the applied divider exponent.
    always_comb begin
        pow = (CNT_W+1)'(1) << div_q;
        lim = CNT_W'(pow - 1'b1);
    end

    assign bnd = in_norm && hs_stable && (cnt_q == lim);

    // Clock-enable source per mode.
    always_comb begin
        unique case (state_q)
            ST_NORMAL:         sys_clk_en = bnd;
            ST_SLOW, ST_HSWAIT: sys_clk_en = ls_tick;
            default:           sys_clk_en = 1'b0;
        endcase
    end

    // Count divided edges and reload the divider at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (!in_norm) begin
            cnt_q <= '0;
            if (clk_sel != SEL_SLOW) div_q <= clk_sel;
        end else if (hs_stable) begin
            if (cnt_q == lim) begin
                cnt_q <= '0;
                if (clk_sel != SEL_SLOW) div_q <= clk_sel;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmc_osc_ctl.sv
// Oscillator enable decode from the current state and the idle-enable bits.
// Assumes the waiting state must power the high-speed oscillator.
module pmc_osc_ctl
    import pmc_pkg::*;
(
    input  pmc_state_e state_q,
    input  logic       hs_idle_en,
    input  logic       ls_idle_en,
    output logic       hs_osc_en,
    output logic       ls_osc_en
);
    // Per-state enable table.
    always_comb begin
        unique case (state_q)
            ST_NORMAL: begin hs_osc_en = 1'b1;       ls_osc_en = ls_idle_en; end
            ST_SLOW:   begin hs_osc_en = hs_idle_en; ls_osc_en = 1'b1;       end
            ST_HSWAIT: begin hs_osc_en = 1'b1;       ls_osc_en = 1'b1;       end
            ST_IDLE0:  begin hs_osc_en = 1'b0;       ls_osc_en = 1'b1;       end
            ST_IDLE1:  begin hs_osc_en = 1'b1;       ls_osc_en = 1'b1;       end
            ST_IDLE2:  begin hs_osc_en = 1'b1;       ls_osc_en = 1'b0;       end
            default:   begin hs_osc_en = 1'b0;       ls_osc_en = 1'b0;       end
        endcase
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
// Power mode and clock controller top: ties the sequencer, divider and oscillator decode.
// Assumes SEL_W = 3 so the mode code and clk_sel share the 3-bit encoding.
module pwr_clk_ctrl
    import pmc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             hs_idle_en,
    input  logic             ls_idle_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             hs_stable,
    input  logic             ls_tick,
    input  logic             wake,
    input  logic             wdt_tmo,
    output logic [2:0]       mode,
    output logic             sys_clk_en,
    output logic [SEL_W-1:0] div_sel,
    output logic             hs_osc_en,
    output logic             ls_osc_en,
    output logic             pd_flag,
    output logic             to_flag,
    output logic             wdt_clr
);
    pmc_state_e st;
    logic       bnd;

    pmc_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
        .hs_idle_en(hs_idle_en), .ls_idle_en(ls_idle_en),
        .clk_sel(clk_sel), .hs_stable(hs_stable), .bnd(bnd),
        .wake(wake), .wdt_tmo(wdt_tmo), .state_q(st),
        .pd_flag(pd_flag), .to_flag(to_flag), .wdt_clr(wdt_clr)
    );

    pmc_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .state_q(st), .clk_sel(clk_sel),
        .hs_stable(hs_stable), .ls_tick(ls_tick), .bnd(bnd),
        .sys_clk_en(sys_clk_en), .div_q(div_sel)
    );

    pmc_osc_ctl u_osc (
        .state_q(st), .hs_idle_en(hs_idle_en), .ls_idle_en(ls_idle_en),
        .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en)
    );

    // The waiting state is reported as SLOW since the core still runs on the slow clock.
    assign mode = (st == ST_HSWAIT) ? 3'(ST_SLOW) : 3'(st);
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
// Property checker for pwr_clk_ctrl, attached by bind; observes top-level ports only.
module pwr_clk_ctrl_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req,
    input logic [SEL_W-1:0] clk_sel,
    input logic             hs_stable,
    input logic             ls_tick,
    input logic [2:0]       mode,
    input logic             sys_clk_en,
    input logic [SEL_W-1:0] div_sel,
    input logic             hs_osc_en,
    input logic             ls_osc_en,
    input logic             pd_flag,
    input logic             to_flag,
    input logic             wdt_clr
);
    AST_LP_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd2) |-> !sys_clk_en); // R6
    AST_SLEEP_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (!hs_osc_en && !ls_osc_en)); // R7
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd5); // R1
    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && mode <= 3'd1) |=> (pd_flag && !to_flag && wdt_clr)); // R8
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr); // R8
    AST_SLOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (sys_clk_en == ls_tick)); // R4
    AST_HS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && clk_sel != '1 && !hs_stable && !halt_req)
        |=> (mode == 3'd1 && hs_osc_en)); // R5
    AST_DIV_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && $past(mode) == 3'd0 && !$stable(div_sel))
        |-> $past(sys_clk_en)); // R3
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 0, hs_idle_en = 0, ls_idle_en = 0;
    logic [2:0] clk_sel = 3'd0;
    logic       hs_stable = 1'b1, ls_tick = 0, wake = 0, wdt_tmo = 0;
    logic [2:0] mode, div_sel;
    logic       sys_clk_en, hs_osc_en, ls_osc_en, pd_flag, to_flag, wdt_clr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    pwr_clk_ctrl u0 (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait (bounded) until mode reaches target.
    task automatic wait_mode(input logic [2:0] m);
        for (int i = 0; i < 200 && mode != m; i++) step(1);
    endtask

    task automatic t_reset();
        step(1);
        chk("R10 mode", mode, 0);
        chk("R10 div_sel", div_sel, 0);
        chk("R10 pd_flag", pd_flag, 0);
        chk("R10 to_flag", to_flag, 0);
        chk("R2 div1 enable", sys_clk_en, 1);
    endtask

    task automatic t_divide();
        int pulses = 0;
        clk_sel = 3'd2;
        step(1);
        chk("R2 div_sel", div_sel, 2);
        for (int i = 0; i < 16; i++) begin step(1); pulses += sys_clk_en; end
        chk("R2 pulses per 16 at div4", pulses, 4);
        clk_sel = 3'd6;
        step(8);
        pulses = 0;
        for (int i = 0; i < 128; i++) begin step(1); pulses += sys_clk_en; end
        chk("R2 pulses per 128 at div64", pulses, 2);
        hs_stable = 0;
        pulses = 0;
        for (int i = 0; i < 80; i++) begin step(1); pulses += sys_clk_en; end
        chk("R2 no pulses while unstable", pulses, 0);
        hs_stable = 1;
    endtask

    task automatic t_change();
        int last = -1, gap_bad = 0, lastgap = 0;
        clk_sel = 3'd3;
        step(140);
        chk("R3 div_sel 3", div_sel, 3);
        clk_sel = 3'd1;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (sys_clk_en) begin
                if (last >= 0) begin
                    lastgap = i - last;
                    if (lastgap != 2 && lastgap != 8) gap_bad++;
                end
                last = i;
            end
        end
        chk("R3 odd intervals", gap_bad, 0);
        chk("R3 final interval", lastgap, 2);
    endtask

    task automatic t_slow();
        int mism = 0;
        hs_idle_en = 0; ls_idle_en = 0;
        clk_sel = 3'd7;
        wait_mode(3'd1);
        chk("R4 enter SLOW", mode, 1);
        chk("R7 hs off in SLOW", hs_osc_en, 0);
        chk("R7 ls on in SLOW", ls_osc_en, 1);
        for (int i = 0; i < 10; i++) begin
            ls_tick = (i % 3 == 0);
            #1;
            if (sys_clk_en != ls_tick) mism++;
            step(1);
        end
        chk("R4 enable follows tick", mism, 0);
        hs_stable = 0;
        clk_sel = 3'd0;
        step(1);
        chk("R5 stalled in SLOW", mode, 1);
        chk("R5 hs osc raised", hs_osc_en, 1);
        ls_tick = 1; #1;
        chk("R5 slow clock held", sys_clk_en, 1);
        ls_tick = 0;
        step(6);
        chk("R5 still stalled", mode, 1);
        hs_stable = 1;
        step(1);
        chk("R5 NORMAL after stable", mode, 0);
    endtask

    task automatic t_halt(input logic h, input logic l, input int exp_mode,
                          input int exp_hs, input int exp_ls);
        clk_sel = 3'd0;
        hs_idle_en = h; ls_idle_en = l;
        wdt_tmo = 1; step(1); wdt_tmo = 0;
        chk("R11 to_flag set", to_flag, 1);
        halt_req = 1; step(1); halt_req = 0;
        chk("R1 halt mode", mode, exp_mode);
        chk("R8 pd_flag", pd_flag, 1);
        chk("R8 to_flag cleared", to_flag, 0);
        chk("R8 wdt_clr", wdt_clr, 1);
        chk("R6 enable off", sys_clk_en, 0);
        chk("R7 hs_osc_en", hs_osc_en, exp_hs);
        chk("R7 ls_osc_en", ls_osc_en, exp_ls);
        step(1);
        chk("R8 wdt_clr single", wdt_clr, 0);
        step(3);
        chk("R9 stays halted", mode, exp_mode);
        wake = 1; step(1); wake = 0;
        chk("R9 back to NORMAL", mode, 0);
    endtask

    task automatic t_halt_slow();
        hs_idle_en = 0; ls_idle_en = 1;
        clk_sel = 3'd7;
        wait_mode(3'd1);
        halt_req = 1; step(1); halt_req = 0;
        chk("R1 IDLE0 from SLOW", mode, 3);
        wake = 1; step(1); wake = 0;
        chk("R9 back to SLOW", mode, 1);
        wake = 1; step(1); wake = 0;
        chk("R9 wake ignored in SLOW", mode, 1);
        clk_sel = 3'd0;
        step(2);
        wake = 1; step(1); wake = 0;
        chk("R9 wake ignored in NORMAL", mode, 0);
        chk("R9 enable unaffected", sys_clk_en, 1);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        t_reset();
        t_divide();
        t_change();
        t_slow();
        t_halt(0, 0, 2, 0, 0);
        t_halt(0, 1, 3, 0, 1);
        t_halt(1, 1, 4, 1, 1);
        t_halt(1, 0, 5, 1, 0);
        t_halt_slow();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule